// File: doc/BRIEF.md
# Window Watchdog with Early Warning

This block supervises a running program with a seven-bit down counter that has to be refreshed inside a time window. Software first writes a window limit and a prescale code, then sets the enable bit together with a start count. From then on the counter steps down once per prescaled interval. A refresh is a write to the control register. If the refresh comes while the count is still above the window limit, it is too early and is treated as a fault. If no refresh comes and the count steps down past 0x40, the watchdog has expired. Either fault drives a reset pulse of fixed length out of the block. A status output tells which of the two faults caused it.

When the count reaches 0x40, one interval before expiry, a sticky early-warning flag is raised as an interrupt. Supervisory code can use that time to put the system into a safe state. Once enabled, the watchdog cannot be switched off, and its window and prescale settings are frozen. Stray code therefore cannot weaken the protection. After a fault the block freezes until the system reset input is applied.

Top module: `window_watchdog`

## Requirements
- R1: After reset the count is 0x7F, the window limit is 0x7F, the prescale code is 0 and every output is low. While the enable bit is clear, the count never changes on its own. A write to address 0 loads its bits 6:0 into the count.
- R2: While enabled, the count falls by one every 2^(BASE_LOG2+p) clocks, where p is the 2-bit prescale code held at address 2. BASE_LOG2 defaults to 12, so the default interval is 4096·2^p clocks. The interval is counted from the edge of the enabling write or of the latest refresh.
- R3: When a step would take the count from 0x40 to 0x3F, the reset pulse starts with cause_early_o = 0, which means expiry. A refresh on that same edge is taken instead of the step.
- R4: A refresh is a write to address 0 while the block is enabled. If the count is above the window limit held at address 1, the refresh starts the reset pulse with cause_early_o = 1, which means too early. If the count is at or below the limit, the count is reloaded from bits 6:0 and the prescale interval restarts.
- R5: A write to address 0 that leaves the block enabled, with bits 6:0 below 0x40 (bit 6 clear), starts an expiry reset on that edge. A too-early refresh is reported as too early, with cause_early_o = 1, even if its value is also below 0x40.
- R6: Bit 7 of an address-0 write sets the enable bit. A write with bit 7 clear does not clear it; only rst_ni does.
- R7: Once enabled, writes to address 1 (window limit) and to address 2 (prescale code) are ignored.
- R8: early_irq_o is set on the edge at which the count becomes 0x40. It stays set until one of two things happens: a write to address 3 with bit 0 set, or the start of a reset pulse.
- R9: wdg_rst_o is high for exactly 8 consecutive cycles. It goes high on the edge that detects the fault.
- R10: After a fault, the count holds and all writes are ignored. No further pulse is produced until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 window, 2 prescale, 3 flag clear |
| wr_data_i | input | CNT_W+1 | Write data |
| wdg_rst_o | output | 1 | Reset pulse |
| early_irq_o | output | 1 | Early-warning interrupt flag |
| cause_early_o | output | 1 | Fault cause: 1 too-early refresh, 0 expiry |
| count_o | output | CNT_W | Current count |

## Verification
The hardest case to reach is a refresh that lands on the very edge where the count would step from 0x40 into expiry. Also hard are refreshes exactly at, and one step above, the window limit. All of these depend on matching the refresh edge to the prescaler phase. The bench shrinks BASE_LOG2 to 2 and starts each vector from a fresh reset. It then places the refresh a computed number of cycles after the enabling write, so the count at the refresh edge is known exactly. One vector misses the last safe edge by a single cycle, so that it expires.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL  = 2'd0,
    REG_WIN   = 2'd1,
    REG_PSC   = 2'd2,
    REG_FLAG  = 2'd3
  } wwdg_reg_e;

  typedef enum logic {
    CAUSE_EXPIRY = 1'b0,
    CAUSE_EARLY  = 1'b1
  } wwdg_cause_e;

  // terminal value of the prescale divider for a given code
  function automatic logic [31:0] tick_limit(input int unsigned base_log2,
                                             input logic [7:0] psc);
    return (32'd1 << (base_log2 + 32'(psc))) - 32'd1;
  endfunction

  // refresh arrives while the count is still above the window limit
  function automatic logic too_early(input logic [7:0] cnt, input logic [7:0] win);
    return cnt > win;
  endfunction

  // a loaded value below the half point counts as already expired
  function automatic logic below_half(input logic [7:0] val, input int unsigned cnt_w);
    return val < (8'd1 << (cnt_w - 1));
  endfunction

endpackage

// File: rtl/wwdg_cfg.sv
module wwdg_cfg #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned PSC_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [wwdg_pkg::REG_AW-1:0]   wr_addr_i,
  input  logic [CNT_W:0]                wr_data_i,
  input  logic                          tripped_i,
  output logic                          en_o,
  output logic                          en_next_o,
  output logic [CNT_W-1:0]              win_o,
  output logic [PSC_W-1:0]              psc_o,
  output logic                          load_o,
  output logic                          kick_o,
  output logic [CNT_W-1:0]              load_val_o,
  output logic                          flag_clr_o
);
  import wwdg_pkg::*;

  logic             en_q;
  logic [CNT_W-1:0] win_q;
  logic [PSC_W-1:0] psc_q;
  logic             wr_ok;
  logic             ctrl_wr, win_wr, psc_wr;

  assign wr_ok   = wr_en_i && !tripped_i;
  assign ctrl_wr = wr_ok && (wr_addr_i == REG_CTRL);
  assign win_wr  = wr_ok && !en_q && (wr_addr_i == REG_WIN);
  assign psc_wr  = wr_ok && !en_q && (wr_addr_i == REG_PSC);

  assign en_next_o  = en_q | (ctrl_wr & wr_data_i[CNT_W]);
  assign load_o     = ctrl_wr;
  assign kick_o     = ctrl_wr & en_q;
  assign load_val_o = wr_data_i[CNT_W-1:0];
  assign flag_clr_o = wr_ok && (wr_addr_i == REG_FLAG) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      win_q <= '1;
      psc_q <= '0;
    end else begin
      en_q <= en_next_o;
      if (win_wr) win_q <= wr_data_i[CNT_W-1:0];
      if (psc_wr) psc_q <= wr_data_i[PSC_W-1:0];
    end
  end

  assign en_o  = en_q;
  assign win_o = win_q;
  assign psc_o = psc_q;

endmodule

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler #(
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned PSC_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = BASE_LOG2 + (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit_w;

  assign limit_w = DIV_W'(wwdg_pkg::tick_limit(BASE_LOG2, 8'(psc_i)));
  assign tick_o  = run_i && !restart_i && (div_q == limit_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          div_q <= '0;
    else if (!run_i || restart_i || tick_o) div_q <= '0;
    else                                  div_q <= div_q + DIV_W'(1);
  end

endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_next_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             warn_o
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == HALF);
  assign warn_o   = (tick_i && (cnt_q == HALF + CNT_W'(1))) ||
                    (load_i && en_next_i && (load_val_i == HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wwdg_fault.sv
module wwdg_fault #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  input  logic             kick_i,
  input  logic             load_i,
  input  logic             en_next_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             warn_i,
  input  logic             flag_clr_i,
  output logic             early_evt_o,
  output logic             fire_o,
  output logic             tripped_o,
  output logic             rst_o,
  output logic             cause_o,
  output logic             irq_o
);
  import wwdg_pkg::*;
  localparam int unsigned PC_W = $clog2(PULSE_LEN + 1);

  logic            bad_load_w;
  logic            tripped_q, rst_q, irq_q;
  wwdg_cause_e     cause_q;
  logic [PC_W-1:0] pulse_q;

  assign early_evt_o = kick_i && too_early(8'(cnt_i), 8'(win_i));
  assign bad_load_w  = load_i && en_next_i && below_half(8'(load_val_i), CNT_W);
  assign fire_o      = !tripped_q && (expire_i || early_evt_o || bad_load_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tripped_q <= 1'b0;
      cause_q   <= CAUSE_EXPIRY;
      pulse_q   <= '0;
      rst_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (fire_o) begin
        tripped_q <= 1'b1;
        cause_q   <= early_evt_o ? CAUSE_EARLY : CAUSE_EXPIRY;
        pulse_q   <= PC_W'(PULSE_LEN);
        rst_q     <= 1'b1;
      end else if (pulse_q != '0) begin
        pulse_q <= pulse_q - PC_W'(1);
        rst_q   <= (pulse_q > PC_W'(1));
      end
      if (fire_o)          irq_q <= 1'b0;
      else if (warn_i)     irq_q <= 1'b1;
      else if (flag_clr_i) irq_q <= 1'b0;
    end
  end

  assign tripped_o = tripped_q;
  assign rst_o     = rst_q;
  assign cause_o   = cause_q;
  assign irq_o     = irq_q;

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned PSC_W     = 2,
  parameter int unsigned BASE_LOG2 = 12,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [wwdg_pkg::REG_AW-1:0] wr_addr_i,
  input  logic [CNT_W:0]              wr_data_i,
  output logic                        wdg_rst_o,
  output logic                        early_irq_o,
  output logic                        cause_early_o,
  output logic [CNT_W-1:0]            count_o
);
  // named internal events, also watched by the bound checker
  logic             en_w, en_next_w, load_w, kick_w, flag_clr_w;
  logic [CNT_W-1:0] win_w, load_val_w, cnt_w;
  logic [PSC_W-1:0] psc_w;
  logic             tick_w, expire_w, warn_w;
  logic             early_w, fire_w, tripped_w;

  wwdg_cfg #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tripped_i  (tripped_w),
    .en_o       (en_w),
    .en_next_o  (en_next_w),
    .win_o      (win_w),
    .psc_o      (psc_w),
    .load_o     (load_w),
    .kick_o     (kick_w),
    .load_val_o (load_val_w),
    .flag_clr_o (flag_clr_w)
  );

  wwdg_prescaler #(.BASE_LOG2(BASE_LOG2), .PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni,
    .run_i     (en_w && !tripped_w),
    .restart_i (load_w),
    .psc_i     (psc_w),
    .tick_o    (tick_w)
  );

  wwdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i     (load_w),
    .en_next_i  (en_next_w),
    .load_val_i (load_val_w),
    .tick_i     (tick_w),
    .cnt_o      (cnt_w),
    .expire_o   (expire_w),
    .warn_o     (warn_w)
  );

  wwdg_fault #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_flt (
    .clk_i, .rst_ni,
    .expire_i    (expire_w),
    .kick_i      (kick_w),
    .load_i      (load_w),
    .en_next_i   (en_next_w),
    .cnt_i       (cnt_w),
    .win_i       (win_w),
    .load_val_i  (load_val_w),
    .warn_i      (warn_w),
    .flag_clr_i  (flag_clr_w),
    .early_evt_o (early_w),
    .fire_o      (fire_w),
    .tripped_o   (tripped_w),
    .rst_o       (wdg_rst_o),
    .cause_o     (cause_early_o),
    .irq_o       (early_irq_o)
  );

  assign count_o = cnt_w;

endmodule

// File: rtl/wwdg_checker.sv
module wwdg_checker #(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned PSC_W     = 2,
  parameter int unsigned PULSE_LEN = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] win_i,
  input logic [PSC_W-1:0] psc_i,
  input logic             kick_i,
  input logic             tick_i,
  input logic             fire_i,
  input logic             tripped_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rst_o_i,
  input logic             cause_i,
  input logic             irq_i
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic [7:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt <= '0;
    else if (rst_o_i) hi_cnt <= hi_cnt + 8'd1;
    else              hi_cnt <= '0;
  end

  assert_enable_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> en_i);

  assert_cfg_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(win_i) && $stable(psc_i)));

  assert_expiry_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == HALF) |=> (rst_o_i && !cause_i));

  assert_early_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && cnt_i > win_i) |=> (rst_o_i && cause_i));

  assert_count_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tripped_i) |-> cnt_i >= HALF);

  assert_warn_point_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> cnt_i == HALF);

  assert_warn_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !irq_i);

  assert_pulse_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o_i) |-> hi_cnt == 8'(PULSE_LEN));

  assert_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tripped_i |=> ($stable(cnt_i) && !fire_i));

endmodule

bind window_watchdog wwdg_checker #(
  .CNT_W(CNT_W), .PSC_W(PSC_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_w),
  .win_i     (win_w),
  .psc_i     (psc_w),
  .kick_i    (kick_w),
  .tick_i    (tick_w),
  .fire_i    (fire_w),
  .tripped_i (tripped_w),
  .cnt_i     (cnt_w),
  .rst_o_i   (wdg_rst_o),
  .cause_i   (cause_early_o),
  .irq_i     (early_irq_o)
);

// File: tb/window_watchdog_tb.sv
module window_watchdog_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wdg_rst, irq, cause;
  logic [6:0] count;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  window_watchdog #(.BASE_LOG2(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wdg_rst_o(wdg_rst), .early_irq_o(irq),
    .cause_early_o(cause), .count_o(count)
  );

  // outcome codes: 0 refresh accepted, 1 too early, 2 expired before refresh
  typedef struct packed {
    logic [1:0] psc;
    logic [6:0] win;
    logic [6:0] load;
    logic [7:0] dly;
    logic [1:0] outc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 7'h50, 7'h7F, 8'd10,  2'd1},
    '{2'd0, 7'h7F, 7'h7F, 8'd10,  2'd0},
    '{2'd0, 7'h50, 7'h52, 8'd9,   2'd0},
    '{2'd0, 7'h50, 7'h53, 8'd9,   2'd1},
    '{2'd1, 7'h60, 7'h44, 8'd40,  2'd0},
    '{2'd1, 7'h60, 7'h44, 8'd41,  2'd2},
    '{2'd2, 7'h7F, 7'h41, 8'd30,  2'd0},
    '{2'd3, 7'h45, 7'h48, 8'd100, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state and no counting while disabled
    do_reset();
    chk("R1 reset count", 32'(count), 32'h7F);
    chk("R1 reset rst", 32'(wdg_rst), 0);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset cause", 32'(cause), 0);
    wr(2'd0, 8'h50);
    repeat (40) @(negedge clk);
    chk("R1 disabled hold", 32'(count), 32'h50);
    chk("R1 disabled no rst", 32'(wdg_rst), 0);

    // R2 R3 R4 vector walk
    foreach (VECS[i]) begin
      do_reset();
      wr(2'd2, {6'd0, VECS[i].psc});
      wr(2'd1, {1'b0, VECS[i].win});
      wr(2'd0, {1'b1, VECS[i].load});
      repeat (int'(VECS[i].dly) - 1) @(negedge clk);
      wr(2'd0, {1'b0, VECS[i].load});
      case (VECS[i].outc)
        2'd0: begin
          chk($sformatf("R4 vec%0d accepted rst", i), 32'(wdg_rst), 0);
          chk($sformatf("R2 vec%0d reloaded", i), 32'(count), 32'(VECS[i].load));
        end
        2'd1: begin
          chk($sformatf("R4 vec%0d early rst", i), 32'(wdg_rst), 1);
          chk($sformatf("R4 vec%0d early cause", i), 32'(cause), 1);
        end
        default: begin
          chk($sformatf("R3 vec%0d expired count", i), 32'(count), 32'h3F);
          chk($sformatf("R3 vec%0d expired cause", i), 32'(cause), 0);
        end
      endcase
    end

    // R2 step timing with prescale code 1 (8 clocks)
    do_reset();
    wr(2'd2, 8'd1);
    wr(2'd0, 8'hFF);
    repeat (15) @(negedge clk);
    chk("R2 before step", 32'(count), 32'h7E);
    @(negedge clk);
    chk("R2 at step", 32'(count), 32'h7D);

    // R6 clearing enable has no effect
    do_reset();
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h7F);
    repeat (4) @(negedge clk);
    chk("R6 still counting", 32'(count), 32'h7E);

    // R7 window and prescale locked after enable
    do_reset();
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h41);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h7F);
    chk("R7 window unchanged", 32'(wdg_rst), 0);
    repeat (4) @(negedge clk);
    chk("R7 prescale unchanged", 32'(count), 32'h7E);

    // R5 bad value on refresh and on enabling write
    do_reset();
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h3A);
    chk("R5 refresh low rst", 32'(wdg_rst), 1);
    chk("R5 refresh low cause", 32'(cause), 0);
    do_reset();
    wr(2'd0, 8'hA0);
    chk("R5 enable low rst", 32'(wdg_rst), 1);
    chk("R5 enable low cause", 32'(cause), 0);

    // R8 sticky flag, cleared by the reset pulse
    do_reset();
    wr(2'd0, 8'hC2);
    repeat (7) @(negedge clk);
    chk("R8 not yet", 32'(irq), 0);
    @(negedge clk);
    chk("R8 set at 0x40", 32'(irq), 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", 32'(irq), 1);
    @(negedge clk);
    chk("R8 cleared by fault", 32'(irq), 0);
    chk("R3 expiry rst", 32'(wdg_rst), 1);

    // R8 software clear, then R9 pulse length and R10 freeze
    do_reset();
    wr(2'd0, 8'hC2);
    repeat (8) @(negedge clk);
    chk("R8 set again", 32'(irq), 1);
    wr(2'd3, 8'h01);
    chk("R8 cleared by write", 32'(irq), 0);
    repeat (2) @(negedge clk);
    chk("R3 not yet expired", 32'(wdg_rst), 0);
    @(negedge clk);
    chk("R3 expired", 32'(wdg_rst), 1);
    chk("R3 expired count", 32'(count), 32'h3F);
    begin
      int hi = 0;
      while (wdg_rst && hi < 20) begin
        hi++;
        @(negedge clk);
      end
      chk("R9 pulse length", 32'(hi), 8);
    end
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'h01);
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        if (wdg_rst) extra++;
        @(negedge clk);
      end
      chk("R10 no second pulse", 32'(extra), 0);
    end
    chk("R10 count frozen", 32'(count), 32'h3F);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule